// File: doc/BRIEF.md
# Partitioned Sub-word SIMD ALU

This block is a 64-bit integer datapath. It reads each operand as a row of narrow elements and applies one operation to all of them in the same cycle. A two-bit select sets the element size for each operation: eight bytes, four halfwords or two words. Carries and borrows never cross an element boundary. The block covers wrapping and clamping add and subtract, per-element minimum and maximum, a byte-wise sum of absolute differences, and a narrowing pack from halfwords to bytes.

The block takes a request when `inValid` is high. On the next rising edge it registers the result and raises `outValid`. When `inValid` is low, the result register holds its last value. An `isSigned` input chooses signed or unsigned meaning for the clamping bounds and for the min/max comparison. The reset is synchronous and clears both the valid flag and the result.

Top module: `simd_lane_alu`

## Requirements
- R1: `outValid` equals the `inValid` of the previous cycle. While `rst` is high at a rising edge, `outValid` and `result` become 0 at that edge.
- R2: Opcode 0 adds and opcode 1 subtracts (A minus B) in each element, modulo the element size. `widthSel` 0 selects 8-bit elements, 1 selects 16-bit and 2 selects 32-bit. Element k occupies bits [k*W +: W], and no carry or borrow passes between elements.
- R3: Opcode 2 (clamping add) and opcode 3 (clamping subtract) with `isSigned`=0 return all-ones in an element whose unsigned sum overflows, and zero in an element whose difference would be negative.
- R4: Opcodes 2 and 3 with `isSigned`=1 return the most positive value (0 followed by ones) or the most negative value (1 followed by zeros) in an element whose two's-complement result is out of range, following the sign of the true result.
- R5: Opcode 4 returns the smaller and opcode 5 the larger of each element pair. The comparison is two's-complement when `isSigned`=1 and unsigned when `isSigned`=0.
- R6: Opcode 6 returns the sum of |A byte − B byte| over all eight unsigned bytes, zero-extended into `result`. Bits 63:16 are always 0.
- R7: Opcode 7 clamps each 16-bit element of A and B to the signed byte range [-128, 127]. A element i goes to result byte i (bits 31:0) and B element i goes to result byte 4+i (bits 63:32).
- R8: `widthSel` = 3, or any opcode from 8 to 15, yields a result of 0. This applies to every opcode.
- R9: When `inValid` is low at a rising edge, `result` keeps its value and the other inputs have no effect.
- R10: Opcodes 6 and 7 give the same result for `widthSel` 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe; inputs are taken when high |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| widthSel | input | 2 | Element size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| opCode | input | 4 | Operation select (0..7 defined) |
| isSigned | input | 1 | Signed bounds and comparison when high |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered packed result |

## Verification
The checker watches four things on every cycle: the one-cycle valid timing, that the result holds on idle cycles, that the upper 48 bits are clear after a byte difference sum, and that reserved widths or opcodes give zero. It also checks one clamping property: an unsigned byte add whose A byte is all-ones must return all-ones in that byte. The arithmetic values themselves can only be shown by the directed scenarios. These cover lane isolation at the three widths, which bound is chosen in each saturating mode, the signed/unsigned split in min/max, the exact difference sum, and the placement and clamping of packed bytes.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDS = 4'd2,
    OP_SUBS = 4'd3,
    OP_MIN  = 4'd4,
    OP_MAX  = 4'd5,
    OP_SAD  = 4'd6,
    OP_PACK = 4'd7
  } simd_op_e;

  typedef enum logic [1:0] {
    EW_8   = 2'd0,
    EW_16  = 2'd1,
    EW_32  = 2'd2,
    EW_RSV = 2'd3
  } elem_w_e;

  typedef struct packed {
    logic       subtract;
    logic       saturate;
    logic       signedMode;
    logic       pickMin;
    logic       pickMax;
    logic       sadSel;
    logic       packSel;
    logic       zeroOut;
    logic [1:0] widthIdx;
  } simd_ctrl_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [1:0] widthSel,
  input  logic       isSigned,
  output simd_ctrl_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.signedMode = isSigned;
    strobes.widthIdx   = widthSel;
    case (opCode)
      OP_ADD:  ;
      OP_SUB:  strobes.subtract = 1'b1;
      OP_ADDS: strobes.saturate = 1'b1;
      OP_SUBS: begin
        strobes.saturate = 1'b1;
        strobes.subtract = 1'b1;
      end
      OP_MIN:  strobes.pickMin = 1'b1;
      OP_MAX:  strobes.pickMax = 1'b1;
      OP_SAD:  strobes.sadSel  = 1'b1;
      OP_PACK: strobes.packSel = 1'b1;
      default: strobes.zeroOut = 1'b1;
    endcase
    if (widthSel == EW_RSV) strobes.zeroOut = 1'b1;
  end

endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          subtract,
  input  logic          saturate,
  input  logic          signedMode,
  input  logic          pickMin,
  input  logic          pickMax,
  output logic [LW-1:0] res
);

  localparam int MSB = LW - 1;

  logic [LW:0]   sumU;
  logic [LW:0]   diffU;
  logic [LW-1:0] arith;
  logic [LW-1:0] satVal;
  logic          overflow;
  logic          aLess;

  assign sumU  = {1'b0, a} + {1'b0, b};
  assign diffU = {1'b0, a} - {1'b0, b};
  assign arith = subtract ? diffU[LW-1:0] : sumU[LW-1:0];

  always_comb begin
    if (signedMode) begin
      if (subtract) overflow = (a[MSB] != b[MSB]) && (diffU[MSB] != a[MSB]);
      else          overflow = (a[MSB] == b[MSB]) && (sumU[MSB] != a[MSB]);
      satVal = a[MSB] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
      aLess  = (a[MSB] != b[MSB]) ? a[MSB] : diffU[LW];
    end else begin
      overflow = subtract ? diffU[LW] : sumU[LW];
      satVal   = subtract ? '0 : '1;
      aLess    = diffU[LW];
    end
  end

  always_comb begin
    if (pickMin)                  res = aLess ? a : b;
    else if (pickMax)             res = aLess ? b : a;
    else if (saturate && overflow) res = satVal;
    else                          res = arith;
  end

endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  simd_ctrl_t        strobes,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  localparam int NBYTES = DATA_W / 8;
  localparam int NHALF  = DATA_W / 16;
  localparam int SAD_W  = 8 + $clog2(NBYTES) + 1;

  logic [DATA_W-1:0] widthRes [3];
  logic [DATA_W-1:0] packWord;
  logic [SAD_W-1:0]  sadAcc;
  logic [7:0]        byteA, byteB, absDiff;
  logic [DATA_W-1:0] nextRes;

  for (genvar gw = 0; gw < 3; gw++) begin : g_width
    localparam int LW = 8 << gw;
    localparam int NL = DATA_W / LW;
    for (genvar ln = 0; ln < NL; ln++) begin : g_lane
      simd_lane #(.LW(LW)) u_lane (
        .a          (opA[ln*LW +: LW]),
        .b          (opB[ln*LW +: LW]),
        .subtract   (strobes.subtract),
        .saturate   (strobes.saturate),
        .signedMode (strobes.signedMode),
        .pickMin    (strobes.pickMin),
        .pickMax    (strobes.pickMax),
        .res        (widthRes[gw][ln*LW +: LW])
      );
    end
  end

  always_comb begin
    sadAcc  = '0;
    byteA   = '0;
    byteB   = '0;
    absDiff = '0;
    for (int i = 0; i < NBYTES; i++) begin
      byteA   = opA[i*8 +: 8];
      byteB   = opB[i*8 +: 8];
      absDiff = (byteA > byteB) ? (byteA - byteB) : (byteB - byteA);
      sadAcc  = sadAcc + {{(SAD_W-8){1'b0}}, absDiff};
    end
  end

  function automatic logic [7:0] clampByte(input logic [15:0] v);
    if (!v[15] && (|v[14:7]))      clampByte = 8'h7F;
    else if (v[15] && !(&v[14:7])) clampByte = 8'h80;
    else                           clampByte = v[7:0];
  endfunction

  for (genvar h = 0; h < NHALF; h++) begin : g_pack
    assign packWord[h*8 +: 8]         = clampByte(opA[h*16 +: 16]);
    assign packWord[(NHALF+h)*8 +: 8] = clampByte(opB[h*16 +: 16]);
  end

  always_comb begin
    if (strobes.zeroOut)     nextRes = '0;
    else if (strobes.sadSel) nextRes = {{(DATA_W-SAD_W){1'b0}}, sadAcc};
    else if (strobes.packSel) nextRes = packWord;
    else begin
      case (strobes.widthIdx)
        EW_8:    nextRes = widthRes[0];
        EW_16:   nextRes = widthRes[1];
        EW_32:   nextRes = widthRes[2];
        default: nextRes = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) result <= nextRes;
    end
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        widthSel,
  input  logic [3:0]        opCode,
  input  logic              isSigned,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  simd_ctrl_t strobes;

  simd_ctrl u_ctrl (
    .opCode   (opCode),
    .widthSel (widthSel),
    .isSigned (isSigned),
    .strobes  (strobes)
  );

  simd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .outValid (outValid),
    .result   (result)
  );

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [DATA_W-1:0] opA,
  input logic [1:0]        widthSel,
  input logic [3:0]        opCode,
  input logic              isSigned,
  input logic              outValid,
  input logic [DATA_W-1:0] result
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && (widthSel == 2'd3 || opCode[3])) |=> (result == '0));

  // R6
  sad_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'd6 && widthSel != 2'd3) |=> (result[DATA_W-1:16] == '0));

  // R3
  usat_top_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opCode == 4'd2 && !isSigned && widthSel == 2'd0 && opA[7:0] == 8'hFF)
      |=> (result[7:0] == 8'hFF));

endmodule

bind simd_lane_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_simd_lane_alu.sv
module tb_simd_lane_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [63:0] opA, opB;
  logic [1:0]  widthSel;
  logic [3:0]  opCode;
  logic        isSigned;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  simd_lane_alu dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .widthSel(widthSel), .opCode(opCode), .isSigned(isSigned),
    .outValid(outValid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [1:0] w, input logic s,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] r, output logic v);
    @(negedge clk);
    opCode = op; widthSel = w; isSigned = s; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    r = result;
    v = outValid;
  endtask

  task automatic t_reset();
    rst = 1'b1; inValid = 1'b1; opA = '1; opB = '1; widthSel = 2'd0;
    opCode = 4'd0; isSigned = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid low in reset", {63'd0, outValid}, 64'd0);
    check("R1 result cleared", result, 64'd0);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid low after reset", {63'd0, outValid}, 64'd0);
  endtask

  task automatic t_wrap();
    logic [63:0] r; logic v;
    runOp(4'd0, 2'd0, 1'b0, 64'h80FF_0102_0304_7F01, 64'h8001_0101_0101_0101, r, v);
    check("R1 valid one cycle later", {63'd0, v}, 64'd1);
    check("R2 add 8-bit wrap", r, 64'h0000_0203_0405_8002);
    runOp(4'd1, 2'd0, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, r, v);
    check("R2 sub 8-bit", r, 64'h0000_0000_0001_00FF);
    runOp(4'd1, 2'd1, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, r, v);
    check("R2 sub 16-bit", r, 64'h0000_0000_0001_FFFF);
    runOp(4'd1, 2'd2, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, r, v);
    check("R2 sub 32-bit", r, 64'h0000_0000_0000_FFFF);
  endtask

  task automatic t_usat();
    logic [63:0] r; logic v;
    runOp(4'd2, 2'd0, 1'b0, 64'hF0F0_0000_0000_0010, 64'h2010_0000_0000_0020, r, v);
    check("R3 unsigned clamp add 8-bit", r, 64'hFFFF_0000_0000_0030);
    runOp(4'd3, 2'd1, 1'b0, 64'h0005_0010_0000_FFFF, 64'h0006_0001_0001_0001, r, v);
    check("R3 unsigned clamp sub 16-bit", r, 64'h0000_000F_0000_FFFE);
  endtask

  task automatic t_ssat();
    logic [63:0] r; logic v;
    runOp(4'd2, 2'd0, 1'b1, 64'h7F80_0000_0000_0005, 64'h0180_0000_0000_00FD, r, v);
    check("R4 signed clamp add 8-bit", r, 64'h7F80_0000_0000_0002);
    runOp(4'd3, 2'd2, 1'b1, 64'h8000_0000_7FFF_FFF0, 64'h0000_0001_FFFF_FFF0, r, v);
    check("R4 signed clamp sub 32-bit", r, 64'h8000_0000_7FFF_FFFF);
  endtask

  task automatic t_minmax();
    logic [63:0] r; logic v;
    runOp(4'd4, 2'd0, 1'b0, 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_FF01, r, v);
    check("R5 unsigned min", r, 64'h0000_0000_0000_0101);
    runOp(4'd4, 2'd0, 1'b1, 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_FF01, r, v);
    check("R5 signed min", r, 64'h0000_0000_0000_FFFF);
    runOp(4'd5, 2'd0, 1'b0, 64'h0000_0000_0000_01FF, 64'h0000_0000_0000_FF01, r, v);
    check("R5 unsigned max", r, 64'h0000_0000_0000_FFFF);
    runOp(4'd5, 2'd1, 1'b1, 64'h0000_0000_8000_7FFF, 64'h0000_0000_7FFF_8000, r, v);
    check("R5 signed max 16-bit", r, 64'h0000_0000_7FFF_7FFF);
  endtask

  task automatic t_sad();
    logic [63:0] r; logic v;
    runOp(4'd6, 2'd0, 1'b0, 64'hFF00_1020_3040_5060, 64'h00FF_2010_4030_6050, r, v);
    check("R6 byte abs-diff sum", r, 64'h0000_0000_0000_025E);
    runOp(4'd6, 2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, r, v);
    check("R6 R10 abs-diff sum maximum", r, 64'h0000_0000_0000_07F8);
  endtask

  task automatic t_pack();
    logic [63:0] r; logic v;
    runOp(4'd7, 2'd0, 1'b0, 64'h7FFF_8000_0012_FFF0, 64'h0080_FF7F_007F_FF80, r, v);
    check("R7 narrowing pack", r, 64'h7F80_7F80_7F80_12F0);
    runOp(4'd7, 2'd1, 1'b0, 64'h7FFF_8000_0012_FFF0, 64'h0080_FF7F_007F_FF80, r, v);
    check("R10 pack ignores width", r, 64'h7F80_7F80_7F80_12F0);
  endtask

  task automatic t_reserved();
    logic [63:0] r; logic v;
    runOp(4'd0, 2'd3, 1'b0, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111, r, v);
    check("R8 reserved width", r, 64'h0);
    runOp(4'd9, 2'd0, 1'b0, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111, r, v);
    check("R8 undefined opcode", r, 64'h0);
  endtask

  task automatic t_hold();
    logic [63:0] r; logic v;
    runOp(4'd0, 2'd1, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, r, v);
    check("R9 setup value", r, 64'h0000_0000_0000_0003);
    @(negedge clk);
    opA = 64'hDEAD_BEEF_0000_0000; opCode = 4'd1; widthSel = 2'd2;
    @(negedge clk);
    @(negedge clk);
    check("R9 result held while idle", result, 64'h0000_0000_0000_0003);
    check("R1 R9 valid low while idle", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wrap();
    t_usat();
    t_ssat();
    t_minmax();
    t_sad();
    t_pack();
    t_reserved();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule